// File: doc/BRIEF.md
# Transmit Acknowledge Retry and Reset Escalation Sequencer

This block supervises the acknowledgement of outgoing Power Delivery messages. When software starts a transmission, the block asks the physical layer to send the message that is already held in the transmit buffer. It then opens an acknowledge window at the end of that packet and waits for a GoodCRC reply that carries the outstanding MessageID. If no such reply arrives, the block resends the same packet up to a programmed number of times. When every attempt has failed, it can move on by itself, first to Soft Reset messages and then to a single Hard Reset.

Each stage has its own enable, its own interrupt and its own MessageID rule. Soft Reset attempts always carry MessageID 0 and are acknowledged only by a GoodCRC with MessageID 0. The Hard Reset is sent once, without retry, and fails if the line stays busy for the whole send window. A software hard-reset command outranks everything else and preempts any sequence in progress. The block only sequences packet requests. Packet encoding and the line driver belong to the physical layer behind the request interface.

Top module: `txack_escalator`

## Requirements
- R1: After reset the block is idle: `phy_req_o` is 0, all five interrupt outputs are 0 and both sticky flags are 0.
- R2: A `start_i` pulse while idle latches `msg_id_i` and requests a packet of kind MESSAGE (`phy_kind_o`=2'b00) with that MessageID. An accepted `phy_eop_i` starts an acknowledge window lasting exactly `ACK_TIMEOUT` cycles.
- R3: During the window, an `ack_i` whose `ack_id_i` equals the outstanding MessageID raises `irq_txsent_o` for one cycle on the next cycle and returns the block to idle. An `ack_i` with any other ID is ignored and does not stop the window.
- R4: When the window expires, if `auto_retry_i` is 1 and fewer than `retry_cnt_i` resends have been made in the current stage, the same kind and MessageID are requested again. Codes 0..3 give 1..4 packets in total. With `auto_retry_i`=0 only one packet is sent.
- R5: When the message attempts are used up, `irq_retryfail_o` pulses for one cycle and `retryfail_flag_o` is set.
- R6: After a retry failure with `auto_soft_i`=1, Soft Reset packets (`phy_kind_o`=2'b01) are requested with MessageID 0 on every attempt, under the same retry count. Only a GoodCRC with ID 0 ends this stage with `irq_txsent_o`.
- R7: When the Soft Reset attempts are used up, `irq_softfail_o` pulses and `softfail_flag_o` is set. If `auto_hard_i`=1, exactly one Hard Reset (`phy_kind_o`=2'b10) is then requested, with no retry.
- R8: In the hard-reset stage, an accepted `phy_eop_i` raises `irq_hardsent_o`. If none arrives within `HARD_WINDOW` cycles of entering the stage, `irq_hardfail_o` is raised instead. Either way the block returns to idle.
- R9: `phy_req_o` is held low while `line_busy_i` is 1, and `phy_eop_i` is accepted only in a cycle in which `phy_req_o` is 1.
- R10: `hard_cmd_i` takes precedence over every other input in every state and enters the hard-reset stage with a fresh window.
- R11: Both sticky flags are cleared by an accepted `start_i` or by `hard_cmd_i`. A `start_i` while the block is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: begin transmitting the buffered message |
| msg_id_i | input | IDW | MessageID of the buffered message |
| auto_retry_i | input | 1 | Enable automatic resends |
| retry_cnt_i | input | 2 | Number of resends per stage (0..3) |
| auto_soft_i | input | 1 | Escalate to Soft Reset after retry failure |
| auto_hard_i | input | 1 | Escalate to Hard Reset after soft failure |
| hard_cmd_i | input | 1 | Pulse: software hard-reset command |
| line_busy_i | input | 1 | Line is occupied; no request may be presented |
| phy_eop_i | input | 1 | Pulse from the PHY: last bit of the requested packet sent |
| ack_i | input | 1 | Pulse: GoodCRC received |
| ack_id_i | input | IDW | MessageID carried by the GoodCRC |
| phy_req_o | output | 1 | Packet request to the PHY |
| phy_kind_o | output | 2 | Requested kind: 00 message, 01 soft reset, 10 hard reset |
| phy_msgid_o | output | IDW | MessageID to place in the requested packet |
| irq_txsent_o | output | 1 | Pulse: acknowledged transmission |
| irq_retryfail_o | output | 1 | Pulse: message attempts exhausted |
| irq_softfail_o | output | 1 | Pulse: soft reset attempts exhausted |
| irq_hardsent_o | output | 1 | Pulse: hard reset sent |
| irq_hardfail_o | output | 1 | Pulse: hard reset could not be sent in time |
| retryfail_flag_o | output | 1 | Sticky retry-fail status |
| softfail_flag_o | output | 1 | Sticky soft-fail status |

## Verification
The assertions assume that the PHY raises `phy_eop_i` only as a single-cycle pulse, and only while a request is visible. They also assume that `ack_i` and `hard_cmd_i` are single-cycle pulses and that the configuration inputs stay constant during a sequence. The bench's PHY model pulses end-of-packet a fixed delay after it sees the request and sends GoodCRC replies a fixed delay after chosen packets. The bench reprograms the configuration only while the block is idle, and it raises the busy line only around a command it issues itself.

// File: rtl/txack_pkg.sv
package txack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_HARD = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PK_MSG  = 2'b00,
    PK_SOFT = 2'b01,
    PK_HARD = 2'b10
  } pkt_kind_e;

  typedef struct packed {
    logic sent;
    logic retry_fail;
    logic soft_fail;
    logic hard_sent;
    logic hard_fail;
  } evt_t;

  localparam int NUM_EVT = 5;

  // a resend is allowed while fewer resends than programmed have happened
  function automatic logic may_resend(input logic en, input logic [1:0] done,
                                      input logic [1:0] limit);
    return en && (done < limit);
  endfunction

  // the kind shown to the PHY for a given stage
  function automatic pkt_kind_e kind_of(input logic in_hard, input logic soft_stage);
    if (in_hard) return PK_HARD;
    return soft_stage ? PK_SOFT : PK_MSG;
  endfunction

endpackage

// File: rtl/txack_win_timer.sv
module txack_win_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/txack_stage_ctrl.sv
module txack_stage_ctrl
  import txack_pkg::*;
#(
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [IDW-1:0] msg_id_i,
  input  logic           auto_retry_i,
  input  logic [1:0]     retry_cnt_i,
  input  logic           auto_soft_i,
  input  logic           auto_hard_i,
  input  logic           hard_cmd_i,
  input  logic           line_busy_i,
  input  logic           phy_eop_i,
  input  logic           ack_i,
  input  logic [IDW-1:0] ack_id_i,
  input  logic           ack_expire_i,
  input  logic           hard_expire_i,
  output logic           phy_req_o,
  output logic [1:0]     phy_kind_o,
  output logic [IDW-1:0] phy_msgid_o,
  output logic           in_wait_o,
  output logic           in_hard_o,
  output logic           ack_hit_o,
  output logic           start_ok_o,
  output evt_t           evt_o
);
  seq_state_e     st_q, st_d;
  logic           soft_q, soft_d;
  logic [1:0]     att_q, att_d;
  logic [IDW-1:0] mid_q, mid_d;

  logic [IDW-1:0] want_id;
  logic           eop_ok;
  logic           resend;
  logic           exhausted;

  assign want_id    = soft_q ? '0 : mid_q;
  assign phy_req_o  = (st_q == ST_SEND || st_q == ST_HARD) && !line_busy_i;
  assign eop_ok     = phy_eop_i && phy_req_o;
  assign ack_hit_o  = (st_q == ST_WAIT) && ack_i && (ack_id_i == want_id);
  assign resend     = may_resend(auto_retry_i, att_q, retry_cnt_i);
  assign exhausted  = (st_q == ST_WAIT) && !ack_hit_o && ack_expire_i && !resend;
  assign start_ok_o = (st_q == ST_IDLE) && start_i && !hard_cmd_i;
  assign in_wait_o  = (st_q == ST_WAIT);
  assign in_hard_o  = (st_q == ST_HARD);

  assign phy_kind_o  = kind_of(st_q == ST_HARD, soft_q);
  assign phy_msgid_o = (st_q == ST_HARD) ? '0 : want_id;

  always_comb begin
    evt_o            = '0;
    evt_o.sent       = ack_hit_o && !hard_cmd_i;
    evt_o.retry_fail = exhausted && !soft_q && !hard_cmd_i;
    evt_o.soft_fail  = exhausted && soft_q && !hard_cmd_i;
    evt_o.hard_sent  = (st_q == ST_HARD) && eop_ok && !hard_cmd_i;
    evt_o.hard_fail  = (st_q == ST_HARD) && !eop_ok && hard_expire_i && !hard_cmd_i;
  end

  always_comb begin
    st_d   = st_q;
    soft_d = soft_q;
    att_d  = att_q;
    mid_d  = mid_q;
    if (hard_cmd_i) begin
      st_d = ST_HARD;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_d   = ST_SEND;
          soft_d = 1'b0;
          att_d  = '0;
          mid_d  = msg_id_i;
        end
        ST_SEND: if (eop_ok) st_d = ST_WAIT;
        ST_WAIT: begin
          if (ack_hit_o) begin
            st_d = ST_IDLE;
          end else if (ack_expire_i) begin
            if (resend) begin
              att_d = att_q + 1'b1;
              st_d  = ST_SEND;
            end else if (!soft_q) begin
              if (auto_soft_i) begin
                soft_d = 1'b1;
                att_d  = '0;
                st_d   = ST_SEND;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              st_d = auto_hard_i ? ST_HARD : ST_IDLE;
            end
          end
        end
        ST_HARD: if (eop_ok || hard_expire_i) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      soft_q <= 1'b0;
      att_q  <= '0;
      mid_q  <= '0;
    end else begin
      st_q   <= st_d;
      soft_q <= soft_d;
      att_q  <= att_d;
      mid_q  <= mid_d;
    end
  end
endmodule

// File: rtl/txack_irq_bank.sv
module txack_irq_bank
  import txack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t evt_i,
  input  logic clr_sticky_i,
  output evt_t irq_o,
  output logic retryfail_flag_o,
  output logic softfail_flag_o
);
  logic [NUM_EVT-1:0] evt_vec, irq_vec;

  assign evt_vec = evt_i;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_vec[g] <= 1'b0;
      else        irq_vec[g] <= evt_vec[g];
    end
  end

  assign irq_o = irq_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retryfail_flag_o <= 1'b0;
      softfail_flag_o  <= 1'b0;
    end else if (clr_sticky_i) begin
      retryfail_flag_o <= 1'b0;
      softfail_flag_o  <= 1'b0;
    end else begin
      if (evt_i.retry_fail) retryfail_flag_o <= 1'b1;
      if (evt_i.soft_fail)  softfail_flag_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/txack_escalator.sv
module txack_escalator
  import txack_pkg::*;
#(
  parameter int IDW         = 3,
  parameter int ACK_TIMEOUT = 1000,
  parameter int HARD_WINDOW = 5000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [IDW-1:0] msg_id_i,
  input  logic           auto_retry_i,
  input  logic [1:0]     retry_cnt_i,
  input  logic           auto_soft_i,
  input  logic           auto_hard_i,
  input  logic           hard_cmd_i,
  input  logic           line_busy_i,
  input  logic           phy_eop_i,
  input  logic           ack_i,
  input  logic [IDW-1:0] ack_id_i,
  output logic           phy_req_o,
  output logic [1:0]     phy_kind_o,
  output logic [IDW-1:0] phy_msgid_o,
  output logic           irq_txsent_o,
  output logic           irq_retryfail_o,
  output logic           irq_softfail_o,
  output logic           irq_hardsent_o,
  output logic           irq_hardfail_o,
  output logic           retryfail_flag_o,
  output logic           softfail_flag_o
);
  logic ack_expire_w, hard_expire_w;
  logic in_wait_w, in_hard_w;
  logic ack_hit_w, start_ok_w;
  evt_t evt_w, irq_w;

  txack_win_timer #(.LIMIT(ACK_TIMEOUT)) u_ack_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr_i(!in_wait_w), .run_i(in_wait_w), .expire_o(ack_expire_w)
  );

  txack_win_timer #(.LIMIT(HARD_WINDOW)) u_hard_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr_i(!in_hard_w || hard_cmd_i), .run_i(in_hard_w), .expire_o(hard_expire_w)
  );

  txack_stage_ctrl #(.IDW(IDW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .msg_id_i(msg_id_i),
    .auto_retry_i(auto_retry_i), .retry_cnt_i(retry_cnt_i),
    .auto_soft_i(auto_soft_i), .auto_hard_i(auto_hard_i),
    .hard_cmd_i(hard_cmd_i), .line_busy_i(line_busy_i),
    .phy_eop_i(phy_eop_i), .ack_i(ack_i), .ack_id_i(ack_id_i),
    .ack_expire_i(ack_expire_w), .hard_expire_i(hard_expire_w),
    .phy_req_o(phy_req_o), .phy_kind_o(phy_kind_o), .phy_msgid_o(phy_msgid_o),
    .in_wait_o(in_wait_w), .in_hard_o(in_hard_w),
    .ack_hit_o(ack_hit_w), .start_ok_o(start_ok_w), .evt_o(evt_w)
  );

  txack_irq_bank u_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_w),
    .clr_sticky_i(start_ok_w || hard_cmd_i),
    .irq_o(irq_w),
    .retryfail_flag_o(retryfail_flag_o), .softfail_flag_o(softfail_flag_o)
  );

  assign irq_txsent_o    = irq_w.sent;
  assign irq_retryfail_o = irq_w.retry_fail;
  assign irq_softfail_o  = irq_w.soft_fail;
  assign irq_hardsent_o  = irq_w.hard_sent;
  assign irq_hardfail_o  = irq_w.hard_fail;
endmodule

// File: rtl/txack_chk.sv
module txack_chk #(
  parameter int IDW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           line_busy_i,
  input logic           hard_cmd_i,
  input logic           phy_eop_i,
  input logic           phy_req_o,
  input logic [1:0]     phy_kind_o,
  input logic [IDW-1:0] phy_msgid_o,
  input logic           irq_txsent_o,
  input logic           irq_retryfail_o,
  input logic           irq_softfail_o,
  input logic           irq_hardsent_o,
  input logic           irq_hardfail_o,
  input logic           retryfail_flag_o,
  input logic           softfail_flag_o,
  input logic           ack_hit_w,
  input logic           hard_expire_w,
  input logic           in_hard_w
);
  // R9
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_busy_i |-> !phy_req_o);

  // R6
  soft_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req_o && phy_kind_o == 2'b01) |-> (phy_msgid_o == '0));

  // R10
  hard_cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_cmd_i |=> (phy_kind_o == 2'b10));

  // R11
  hard_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_cmd_i |=> (!retryfail_flag_o && !softfail_flag_o));

  // R3
  ack_gives_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit_w && !hard_cmd_i) |=> irq_txsent_o);

  // R8
  hard_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hard_w && hard_expire_w && !(phy_eop_i && phy_req_o) && !hard_cmd_i) |=> irq_hardfail_o);

  // R5
  retry_flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retryfail_flag_o) |-> irq_retryfail_o);

  // R7
  soft_flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(softfail_flag_o) |-> irq_softfail_o);

  // R1
  single_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_txsent_o, irq_retryfail_o, irq_softfail_o, irq_hardsent_o, irq_hardfail_o}));
endmodule

bind txack_escalator txack_chk #(.IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_busy_i(line_busy_i), .hard_cmd_i(hard_cmd_i),
  .phy_eop_i(phy_eop_i), .phy_req_o(phy_req_o), .phy_kind_o(phy_kind_o),
  .phy_msgid_o(phy_msgid_o), .irq_txsent_o(irq_txsent_o),
  .irq_retryfail_o(irq_retryfail_o), .irq_softfail_o(irq_softfail_o),
  .irq_hardsent_o(irq_hardsent_o), .irq_hardfail_o(irq_hardfail_o),
  .retryfail_flag_o(retryfail_flag_o), .softfail_flag_o(softfail_flag_o),
  .ack_hit_w(ack_hit_w), .hard_expire_w(hard_expire_w), .in_hard_w(in_hard_w)
);

// File: tb/txack_escalator_bench.sv
module txack_escalator_bench;
  localparam int CLK_P    = 10;
  localparam int IDW      = 3;
  localparam int ACK_TO   = 20;
  localparam int HARD_WIN = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ar = 0, soft_en = 0, hard_en = 0, hcmd = 0, busy = 0, eop = 0, ack = 0;
  logic [1:0] rc = 0;
  logic [IDW-1:0] mid_in = 0, ack_id = 0;
  logic req, i_sent, i_rf, i_sf, i_hs, i_hf, f_rf, f_sf;
  logic [1:0] kind;
  logic [IDW-1:0] out_id;

  always #(CLK_P/2) clk = ~clk;

  txack_escalator #(.IDW(IDW), .ACK_TIMEOUT(ACK_TO), .HARD_WINDOW(HARD_WIN)) u_txack_escalator (
    .clk(clk), .rst_n(rst_n), .start_i(start), .msg_id_i(mid_in),
    .auto_retry_i(ar), .retry_cnt_i(rc), .auto_soft_i(soft_en), .auto_hard_i(hard_en),
    .hard_cmd_i(hcmd), .line_busy_i(busy), .phy_eop_i(eop), .ack_i(ack), .ack_id_i(ack_id),
    .phy_req_o(req), .phy_kind_o(kind), .phy_msgid_o(out_id),
    .irq_txsent_o(i_sent), .irq_retryfail_o(i_rf), .irq_softfail_o(i_sf),
    .irq_hardsent_o(i_hs), .irq_hardfail_o(i_hf),
    .retryfail_flag_o(f_rf), .softfail_flag_o(f_sf)
  );

  int errs = 0, checks = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 sending, 2 awaiting ack, 3 hard reset
  int m_st = 0, m_att = 0, m_mid = 0, m_tmr = 0;
  bit m_soft = 0, m_rf = 0, m_sf = 0;
  bit m_sent = 0, m_irf = 0, m_isf = 0, m_ihs = 0, m_ihf = 0;
  int pkts = 0, ack_cd = 0, ack_skip = 0, ack_dly = 5;
  bit ack_en = 0, phy_on = 1;
  logic [IDW-1:0] ack_plan = 0;
  int n_sent = 0, n_rf = 0, n_sf = 0, n_hs = 0, n_hf = 0;

  function automatic bit m_req();
    return (m_st == 1 || m_st == 3) && !busy;
  endfunction

  always @(posedge clk) begin
    bit eop_ok;
    eop_ok = eop && m_req();
    m_sent = 0; m_irf = 0; m_isf = 0; m_ihs = 0; m_ihf = 0;
    if (!rst_n) begin
      m_st = 0; m_att = 0; m_mid = 0; m_tmr = 0; m_soft = 0; m_rf = 0; m_sf = 0;
    end else begin
      if (eop_ok) begin
        pkts++;
        if (ack_en && pkts > ack_skip) ack_cd = ack_dly;
      end
      if (hcmd) begin
        m_st = 3; m_tmr = 0; m_rf = 0; m_sf = 0;
      end else if (m_st == 0) begin
        if (start) begin
          m_st = 1; m_soft = 0; m_att = 0; m_mid = int'(mid_in); m_rf = 0; m_sf = 0;
        end
      end else if (m_st == 1) begin
        if (eop_ok) begin m_st = 2; m_tmr = 0; end
      end else if (m_st == 2) begin
        if (ack && int'(ack_id) == (m_soft ? 0 : m_mid)) begin
          m_sent = 1; m_st = 0;
        end else if (m_tmr == ACK_TO - 1) begin
          if (ar && m_att < int'(rc)) begin
            m_att++; m_st = 1;
          end else if (!m_soft) begin
            m_irf = 1; m_rf = 1;
            if (soft_en) begin m_soft = 1; m_att = 0; m_st = 1; end
            else m_st = 0;
          end else begin
            m_isf = 1; m_sf = 1;
            if (hard_en) begin m_st = 3; m_tmr = 0; end
            else m_st = 0;
          end
        end else m_tmr++;
      end else begin
        if (eop_ok) begin m_ihs = 1; m_st = 0; end
        else if (m_tmr == HARD_WIN - 1) begin m_ihf = 1; m_st = 0; end
        else m_tmr++;
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req == m_req(), "R9", "phy_req", int'(req), int'(m_req()));
      if (m_req()) begin
        int ek, ei;
        ek = (m_st == 3) ? 2 : (m_soft ? 1 : 0);
        ei = (m_st == 3 || m_soft) ? 0 : m_mid;
        chk(int'(kind) == ek, "R6", "phy_kind", int'(kind), ek);
        chk(int'(out_id) == ei, "R2", "phy_msgid", int'(out_id), ei);
      end
      chk(i_sent == m_sent, "R3", "irq_txsent", int'(i_sent), int'(m_sent));
      chk(i_rf == m_irf, "R5", "irq_retryfail", int'(i_rf), int'(m_irf));
      chk(i_sf == m_isf, "R7", "irq_softfail", int'(i_sf), int'(m_isf));
      chk(i_hs == m_ihs, "R8", "irq_hardsent", int'(i_hs), int'(m_ihs));
      chk(i_hf == m_ihf, "R8", "irq_hardfail", int'(i_hf), int'(m_ihf));
      chk(f_rf == m_rf, "R11", "retryfail_flag", int'(f_rf), int'(m_rf));
      chk(f_sf == m_sf, "R11", "softfail_flag", int'(f_sf), int'(m_sf));
      n_sent += int'(i_sent); n_rf += int'(i_rf); n_sf += int'(i_sf);
      n_hs += int'(i_hs); n_hf += int'(i_hf);
    end
  end

  // PHY and link partner model
  int lat = 0;
  always @(negedge clk) begin
    #2;
    eop = 0;
    if (phy_on && req) begin
      if (lat == 3) begin eop = 1; lat = 0; end
      else lat++;
    end
    ack = 0;
    if (ack_cd > 0) begin
      ack_cd--;
      if (ack_cd == 0) begin ack = 1; ack_id = ack_plan; end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_idle();
    int guard = 0;
    tick(1);
    while (m_st != 0 && guard < 2000) begin tick(1); guard++; end
    tick(3);
  endtask

  task automatic setup(input bit a, input int r, input bit s, input bit h,
                       input bit ae, input int skip, input int plan);
    ar = a; rc = 2'(r); soft_en = s; hard_en = h;
    ack_en = ae; ack_skip = skip; ack_plan = IDW'(plan);
    pkts = 0; n_sent = 0; n_rf = 0; n_sf = 0; n_hs = 0; n_hf = 0;
  endtask

  task automatic kick(input int id);
    mid_in = IDW'(id); start = 1; tick(1); start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state
    chk(req == 0, "R1", "req in reset", int'(req), 0);
    chk({i_sent, i_rf, i_sf, i_hs, i_hf} == 0, "R1", "irqs in reset", int'({i_sent, i_rf, i_sf, i_hs, i_hf}), 0);
    chk({f_rf, f_sf} == 0, "R1", "flags in reset", int'({f_rf, f_sf}), 0);
    rst_n = 1; tick(2);

    // R2 R3: acknowledged on first packet
    setup(1, 0, 0, 0, 1, 0, 5); kick(5); wait_idle();
    chk(pkts == 1, "R2", "packets", pkts, 1);
    chk(n_sent == 1, "R3", "txsent count", n_sent, 1);

    // R3 R5: mismatching ack ignored, retries run out
    setup(1, 1, 0, 0, 1, 0, 3); kick(5); wait_idle();
    chk(pkts == 2, "R3", "packets with wrong id", pkts, 2);
    chk(n_sent == 0 && n_rf == 1, "R5", "retryfail count", n_rf, 1);
    chk(f_rf == 1, "R5", "retryfail sticky", int'(f_rf), 1);

    // R4: auto retry off sends one packet only
    setup(0, 3, 0, 0, 0, 0, 0); kick(2); wait_idle();
    chk(pkts == 1, "R4", "packets no retry", pkts, 1);

    // R4 R11: count 3 gives four packets; start while busy ignored
    setup(1, 3, 0, 0, 0, 0, 0); kick(1); tick(10); kick(6); wait_idle();
    chk(pkts == 4, "R4", "packets count3", pkts, 4);
    chk(n_rf == 1, "R11", "second start ignored", n_rf, 1);

    // R6 R11: soft reset acked with id 0; start cleared the flag first
    setup(1, 1, 1, 0, 1, 2, 0); kick(6);
    chk(f_rf == 0, "R11", "flag cleared by start", int'(f_rf), 0);
    wait_idle();
    chk(pkts == 3, "R6", "packets soft ok", pkts, 3);
    chk(n_sent == 1 && n_sf == 0, "R6", "soft success", n_sent, 1);

    // R7 R8: soft ignores message id, escalates to one hard reset
    setup(1, 0, 1, 1, 1, 1, 4); kick(4); wait_idle();
    chk(pkts == 3, "R7", "packets escalation", pkts, 3);
    chk(n_sf == 1 && f_sf == 1, "R7", "softfail", n_sf, 1);
    chk(n_hs == 1, "R8", "hardsent", n_hs, 1);

    // R8 R9 R10: busy line blocks hard reset until window ends
    setup(1, 0, 0, 0, 0, 0, 0); busy = 1; hcmd = 1; tick(1); hcmd = 0;
    chk(f_sf == 0, "R11", "flag cleared by hard cmd", int'(f_sf), 0);
    wait_idle(); busy = 0;
    chk(n_hf == 1 && pkts == 0, "R8", "hardfail", n_hf, 1);

    // R10: hard command preempts an acknowledge wait
    setup(1, 3, 0, 0, 0, 0, 0); kick(7); tick(8); hcmd = 1; tick(1); hcmd = 0; wait_idle();
    chk(n_hs == 1 && n_rf == 0, "R10", "preempt hardsent", n_hs, 1);
    chk(pkts == 2, "R10", "packets preempt", pkts, 2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule